// File: doc/BRIEF.md
# MDIO Management Frame Engine

This block runs clause-22 management transactions toward an external PHY. Software loads one 32-bit command word that carries every field of the frame. The block then clocks that word out on a management clock (MDC) and a shared, bidirectional data line (MDIO). A 32-bit preamble of ones goes first. After that the frame goes out most significant bit first. On a read, the block releases the line for the turnaround and data bits. It captures the sixteen bits returned by the PHY into the low half of the same command word, and software reads them back from there.

MDC is made from the system clock by a divider. The divider is chosen per transaction from four settings. Software picks the smallest setting that keeps MDC within the PHY's limit:
- 8 for system clocks up to 20 MHz
- 16 up to 40 MHz
- 32 up to 80 MHz
- 64 for faster clocks

An idle flag reports when the engine is free and the result is valid. A management enable input gates all activity.

Top module: `mdio_mgmt_engine`

## Requirements
- R1: After reset, `idle` is 1, `mdc` is 0, `mdio_oe` is 0 and `cmd_rdata` is zero. Whenever `idle` is 1, `mdc` is 0 and the line is released.
- R2: A `cmd_wr` pulse while `idle` is 1 and `mgmt_en` is 1 loads `cmd_wdata` into the command word. The command word is laid out from the top down as follows:
  - bits 31:30: start code
  - bits 29:28: operation
  - bits 27:23: PHY address
  - bits 22:18: register address
  - bits 17:16: turnaround code
  - bits 15:0: data

  `idle` drops on the next cycle, and `cmd_rdata` shows the loaded word.
- R3: A transaction drives `PREAMBLE_BITS` ones, then the 32 command bits from bit 31 down to bit 0, with one bit per MDC period. `idle` returns to 1 exactly (`PREAMBLE_BITS`+32) MDC periods after the command was taken.
- R4: The MDC period is 2^(`DIV_MIN_LOG2`+`div_sel`) system clocks. With the defaults this gives 8, 16, 32 or 64 for `div_sel` = 0..3. The divider setting is captured when the command is taken. Each MDC period starts with its low half, and both halves are equal.
- R5: `mdio_o` and `mdio_oe` never change on the cycle in which `mdc` rises.
- R6: When the operation field (bits 29:28) is 2'b10, the transaction is a read. A read drives the first 14 frame bits and releases the line (`mdio_oe` = 0) for the last 18.
- R7: On a read, `mdio_i` is sampled at each MDC rising edge of the 16 data bit periods. The samples fill `cmd_rdata[15:0]` from bit 15 down to bit 0.
- R8: A `cmd_wr` while a transaction is running is ignored. The command word is left unchanged.
- R9: While `mgmt_en` is 0, `cmd_wr` is ignored. Dropping `mgmt_en` during a transaction aborts it: on the next cycle `idle` is 1 and the line is released, and the command word keeps its value.
- R10: Any operation other than a read drives all 32 frame bits, including the turnaround code exactly as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mgmt_en | input | 1 | Management port enable |
| div_sel | input | 2 | MDC divider select, captured at command |
| cmd_wr | input | 1 | Write strobe for the command word |
| cmd_wdata | input | 32 | Command word to load |
| cmd_rdata | output | 32 | Current command word, with read data in 15:0 |
| idle | output | 1 | High when no transaction is in progress |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
The bench builds the engine with `PREAMBLE_BITS` = 8 and the default `DIV_MIN_LOG2` = 3. The shorter preamble keeps even the slowest divider transaction at 2560 clocks. That leaves room to run all four divider settings, both read and write frames, a write attempted while busy, a write attempted while disabled, and an abort in mid-frame. The divider widths are the production ones, so the MDC timing is checked at the real ratios.

// File: rtl/mdio_mgmt_engine.sv
module mdio_mgmt_engine #(
  parameter int PREAMBLE_BITS = 32,
  parameter int DIV_MIN_LOG2  = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mgmt_en,
  input  logic [1:0]  div_sel,
  input  logic        cmd_wr,
  input  logic [31:0] cmd_wdata,
  output logic [31:0] cmd_rdata,
  output logic        idle,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int TOTAL = PREAMBLE_BITS + 32;
  localparam int BW    = $clog2(TOTAL);
  localparam int CW    = DIV_MIN_LOG2 + 2;

  logic          busy, rd_op, in_pre, edge_now, accept;
  logic [1:0]    sel_q;
  logic [CW-1:0] cnt, half_m1;
  logic [BW-1:0] bitn;
  logic [4:0]    fpos;
  logic [31:0]   mreg;

  assign half_m1  = CW'((32'd1 << (DIV_MIN_LOG2 - 1 + int'(sel_q))) - 32'd1);
  assign in_pre   = bitn < BW'(PREAMBLE_BITS);
  assign fpos     = 5'(BW'(TOTAL - 1) - bitn);
  assign edge_now = busy & (cnt == half_m1);
  assign accept   = cmd_wr & mgmt_en & ~busy;

  assign mdio_oe   = busy & (in_pre | ~rd_op | (fpos >= 5'd18));
  assign mdio_o    = mdio_oe & (in_pre | mreg[fpos]);
  assign idle      = ~busy;
  assign cmd_rdata = mreg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      rd_op <= 1'b0;
      sel_q <= '0;
      cnt   <= '0;
      bitn  <= '0;
      mdc   <= 1'b0;
      mreg  <= '0;
    end else if (accept) begin
      mreg  <= cmd_wdata;
      rd_op <= (cmd_wdata[29:28] == 2'b10);
      sel_q <= div_sel;
      busy  <= 1'b1;
      cnt   <= '0;
      bitn  <= '0;
      mdc   <= 1'b0;
    end else if (busy && !mgmt_en) begin
      busy <= 1'b0;
      mdc  <= 1'b0;
    end else if (edge_now) begin
      cnt <= '0;
      mdc <= ~mdc;
      if (!mdc) begin
        if (rd_op && !in_pre && fpos <= 5'd15)
          mreg[fpos] <= mdio_i;
      end else if (bitn == BW'(TOTAL - 1)) begin
        busy <= 1'b0;
      end else begin
        bitn <= bitn + 1'b1;
      end
    end else if (busy) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_mgmt_engine_chk.sv
module mdio_mgmt_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mgmt_en,
  input logic        idle,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic [31:0] cmd_rdata
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> (!mdc && !mdio_oe));

  assert_stable_at_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc) |-> ($stable(mdio_o) && $stable(mdio_oe)));

  assert_release_only_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && !mdio_oe) |-> (cmd_rdata[29:28] == 2'b10));

  assert_busy_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && $past(!idle)) |-> $stable(cmd_rdata[31:16]));

  assert_disable_aborts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !mgmt_en |=> idle);
endmodule

bind mdio_mgmt_engine mdio_mgmt_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mgmt_en(mgmt_en), .idle(idle), .mdc(mdc),
  .mdio_o(mdio_o), .mdio_oe(mdio_oe), .cmd_rdata(cmd_rdata)
);

// File: tb/test_mdio_mgmt_engine.sv
module test_mdio_mgmt_engine;
  localparam int PRE  = 8;
  localparam int DMIN = 3;
  localparam int TOT  = PRE + 32;

  logic clk = 1'b0, rst_n = 1'b0, mgmt_en = 1'b0, cmd_wr = 1'b0, mdio_i = 1'b0;
  logic [1:0] div_sel = '0;
  logic [31:0] cmd_wdata = '0, cmd_rdata;
  logic idle, mdc, mdio_o, mdio_oe;

  int n_chk = 0, n_fail = 0, cycles = 0;
  bit m_busy = 0, m_rd = 0;
  logic [31:0] m_reg = '0;
  int m_t = 0, m_per = 8;
  logic [15:0] phy_word = '0;

  mdio_mgmt_engine #(.PREAMBLE_BITS(PRE), .DIV_MIN_LOG2(DMIN)) i_mdio_mgmt_engine (
    .clk(clk), .rst_n(rst_n), .mgmt_en(mgmt_en), .div_sel(div_sel),
    .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata), .cmd_rdata(cmd_rdata),
    .idle(idle), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_busy = 0; m_reg = '0; m_t = 0;
    end else if (m_busy && !mgmt_en) begin
      m_busy = 0;
    end else if (m_busy) begin
      m_t++;
      if (m_t % m_per == m_per / 2) begin
        if (m_rd && (m_t / m_per - PRE) >= 16)
          m_reg[31 - (m_t / m_per - PRE)] = mdio_i;
      end
      if (m_t == TOT * m_per) m_busy = 0;
    end else if (cmd_wr && mgmt_en) begin
      m_busy = 1; m_reg = cmd_wdata; m_t = 0;
      m_per = 1 << (DMIN + int'(div_sel));
      m_rd = (cmd_wdata[29:28] == 2'b10);
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      int b;
      bit e_mdc, e_oe, e_o;
      b = m_t / m_per;
      e_mdc = m_busy && ((m_t % m_per) >= m_per / 2);
      e_oe = m_busy && (b < PRE || !m_rd || (b - PRE) < 14);
      e_o = e_oe && (b < PRE || m_reg[31 - (b - PRE)]);
      chk(idle == !m_busy, "R3 idle", 32'(idle), 32'(!m_busy));
      chk(mdc == e_mdc, "R4 mdc", 32'(mdc), 32'(e_mdc));
      chk(mdio_oe == e_oe, "R6 mdio_oe", 32'(mdio_oe), 32'(e_oe));
      chk(mdio_o == e_o, "R3 mdio_o", 32'(mdio_o), 32'(e_o));
      chk(cmd_rdata == m_reg, "R2 cmd_rdata", cmd_rdata, m_reg);
      if (m_busy && m_rd && (b - PRE) >= 16) mdio_i <= phy_word[31 - (b - PRE)];
      else mdio_i <= 1'b1;
    end
  end

  task automatic issue(input logic [1:0] sel, input logic [31:0] w);
    @(negedge clk);
    div_sel = sel; cmd_wdata = w; cmd_wr = 1'b1;
    @(negedge clk);
    cmd_wr = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (!idle && n < 20000) begin @(negedge clk); n++; end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #3000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int n;
    logic [31:0] w;
    repeat (4) @(negedge clk);
    chk(idle === 1'b1 && mdc === 1'b0 && mdio_oe === 1'b0, "R1 reset outputs",
        {29'b0, idle, mdc, mdio_oe}, 32'h4);
    chk(cmd_rdata === 32'h0, "R1 reset word", cmd_rdata, 32'h0);
    rst_n = 1'b1; mgmt_en = 1'b1;

    w = {2'b01, 2'b01, 5'h05, 5'h1A, 2'b10, 16'hBEEF};
    issue(2'd0, w);
    chk(!idle && cmd_rdata == w, "R2 load on write", cmd_rdata, w);
    wait_idle(n);
    chk(n == TOT * 8, "R3 R10 write length div8", 32'(n), 32'(TOT * 8));
    chk(cmd_rdata == w, "R10 word after write", cmd_rdata, w);

    phy_word = 16'hA55A;
    w = {2'b01, 2'b10, 5'h11, 5'h02, 2'b10, 16'h0000};
    issue(2'd1, w);
    wait_idle(n);
    chk(n == TOT * 16, "R4 read length div16", 32'(n), 32'(TOT * 16));
    chk(cmd_rdata[15:0] == 16'hA55A, "R7 read data", 32'(cmd_rdata[15:0]), 32'hA55A);
    chk(cmd_rdata[31:16] == w[31:16], "R7 header kept", 32'(cmd_rdata[31:16]), 32'(w[31:16]));

    phy_word = 16'h0F31;
    w = {2'b01, 2'b10, 5'h1F, 5'h1F, 2'b10, 16'hFFFF};
    issue(2'd2, w);
    repeat (50) @(negedge clk);
    issue(2'd0, 32'h5A5A_1234);
    chk(cmd_rdata[31:16] == w[31:16], "R8 busy write ignored", cmd_rdata, w);
    wait_idle(n);
    chk(n == TOT * 32 - 52, "R4 read length div32", 32'(n), 32'(TOT * 32 - 52));
    chk(cmd_rdata == {w[31:16], 16'h0F31}, "R8 R7 result", cmd_rdata, {w[31:16], 16'h0F31});

    w = {2'b01, 2'b01, 5'h00, 5'h10, 2'b10, 16'h8001};
    issue(2'd3, w);
    wait_idle(n);
    chk(n == TOT * 64, "R4 write length div64", 32'(n), 32'(TOT * 64));

    mgmt_en = 1'b0;
    issue(2'd0, 32'h1234_5678);
    chk(idle && cmd_rdata == w, "R9 disabled write ignored", cmd_rdata, w);
    repeat (3) @(negedge clk);
    chk(idle && !mdc && !mdio_oe, "R9 stays quiet", {31'b0, idle}, 32'h1);

    mgmt_en = 1'b1;
    w = {2'b01, 2'b01, 5'h0A, 5'h05, 2'b10, 16'h00FF};
    issue(2'd0, w);
    repeat (100) @(negedge clk);
    chk(!idle, "R9 running before abort", {31'b0, idle}, 32'h0);
    mgmt_en = 1'b0;
    @(negedge clk);
    chk(idle && !mdio_oe && !mdc, "R9 abort", {29'b0, idle, mdio_oe, mdc}, 32'h4);
    chk(cmd_rdata == w, "R9 word kept", cmd_rdata, w);
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule